// File: doc/BRIEF.md
# XOR-Indexed Bit Permutation Unit

This block rearranges the bits of an operand under runtime control. Every source bit at index i is moved to index i XOR k, where k is a control amount. The same hardware covers a full bit reversal (k all ones), a reversal of byte order (k selecting the upper index bits), swaps of nibbles within bytes, swaps of adjacent bits, and every mix of these. The operand is treated as 64 bits wide, or as a 32-bit word when the narrow-mode flag is set; the control amount is reduced to the operating width before it is applied.

The control amount comes either from the low bits of a register operand or from an immediate field, picked per operation by a select input. When the record flag is set, a 4-bit condition field classifies the 64-bit result as a signed number. Operations are presented with a valid strobe and the result and condition field are registered, appearing one clock later with their own valid strobe. A new operation can be issued on every clock.

Top module: `xperm_unit`

## Requirements
- R1: After reset, and until the first accepted operation, `out_valid` is 0, `result` is all zeros and `cond` is 0000.
- R2: `out_valid` is 1 in exactly the cycle that follows a cycle with `in_valid` at 1, so back-to-back operations stream at one per clock.
- R3: With `narrow` at 0, the amount k is taken as 6 bits (modulo 64) and result bit (i XOR k) equals source bit i for every i from 0 to 63.
- R4: With `narrow` at 1, k is the amount modulo 32 (bit 5 discarded), result bit (i XOR k) equals source bit i for i from 0 to 31, and result bits 63 to 32 are zero whatever the source holds there.
- R5: With `use_imm` at 1 the amount is `amt_imm`; with `use_imm` at 0 it is `amt_reg`; the unselected one has no effect on the result.
- R6: An amount of 0 returns the operand unchanged (upper half cleared in narrow mode); an amount of all ones reverses the bit order across the operating width, and 56 in wide mode reverses the byte order.
- R7: With `rec_en` at 1, `cond` bit 3 is set when the 64-bit result is negative (bit 63 set), bit 2 when it is positive and non-zero, bit 1 when it is zero; bit 0 is always 0, so exactly one of bits 3..1 is set.
- R8: With `rec_en` at 0, `cond` is 0000.
- R9: In a cycle following one with `in_valid` at 0, `result` and `cond` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| src_data | input | 64 | Operand to permute |
| amt_reg | input | 6 | Control amount from the register operand (low bits) |
| amt_imm | input | 6 | Control amount from the immediate field |
| use_imm | input | 1 | 1 selects `amt_imm`, 0 selects `amt_reg` |
| narrow | input | 1 | 1 selects 32-bit word operation |
| rec_en | input | 1 | 1 produces the condition field |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 64 | Permuted operand |
| cond | output | 4 | Condition field: bit 3 negative, bit 2 positive, bit 1 zero, bit 0 zero |

## Verification
The permutation is driven with structured constants whose expected images are easy to recognise (a rising nibble sequence for byte reversal and nibble swaps, single set bits that reveal where one index lands) and with a stream of pseudo-random operands and amounts that exercise every butterfly stage in combination. Amounts of zero and all ones separate pass-through from full reversal, and narrow-mode cases with garbage in the upper half and an amount with bit 5 set show that the upper half is cleared and the amount is reduced. Register and immediate amounts are given different values so that picking the wrong source changes the result, and results chosen to be negative, positive and zero each light a different condition bit, while the same operands with recording off must leave the field clear.

// File: rtl/xperm_pkg.sv
package xperm_pkg;

   // condition field bit positions
   localparam int CND_NEG  = 3;
   localparam int CND_POS  = 2;
   localparam int CND_ZERO = 1;
   localparam int CND_RSVD = 0;
   localparam int CND_W    = 4;

   typedef logic [CND_W-1:0] cond_t;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/xperm_amt_sel.sv
module xperm_amt_sel #(
   parameter int DATA_W   = 64,
   parameter int NARROW_W = 32,
   localparam int SH_W    = $clog2(DATA_W),
   localparam int NSH_W   = $clog2(NARROW_W)
) (
   input  logic [SH_W-1:0] amt_reg,
   input  logic [SH_W-1:0] amt_imm,
   input  logic            use_imm,
   input  logic            narrow,
   output logic [SH_W-1:0] amt_eff
);

   logic [SH_W-1:0] picked;
   logic [SH_W-1:0] keep_mask;

   assign picked = use_imm ? amt_imm : amt_reg;

   // narrow mode keeps only the bits that index within the word
   genvar b;
   generate
      for (b = 0; b < SH_W; b++) begin : g_mask
         if (b < NSH_W) begin : g_low
            assign keep_mask[b] = 1'b1;
         end else begin : g_high
            assign keep_mask[b] = ~narrow;
         end
      end
   endgenerate

   assign amt_eff = picked & keep_mask;

endmodule

// File: rtl/xperm_stage.sv
module xperm_stage #(
   parameter int DATA_W = 64,
   parameter int LEVEL  = 0
) (
   input  logic              swap,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);

   localparam int SPAN = 1 << LEVEL;

   // each bit trades places with the bit whose index differs in bit LEVEL
   genvar j;
   generate
      for (j = 0; j < DATA_W; j++) begin : g_bit
         localparam int PARTNER = j ^ SPAN;
         assign dout[j] = swap ? din[PARTNER] : din[j];
      end
   endgenerate

endmodule

// File: rtl/xperm_network.sv
module xperm_network #(
   parameter int DATA_W   = 64,
   parameter int NARROW_W = 32,
   localparam int SH_W    = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] src,
   input  logic [SH_W-1:0]   amt,
   input  logic              narrow,
   output logic [DATA_W-1:0] dst
);

   logic [DATA_W-1:0] lvl [SH_W+1];
   logic [DATA_W-1:0] hi_keep;

   // clear the upper part in narrow mode so it cannot reach the result
   genvar h;
   generate
      for (h = 0; h < DATA_W; h++) begin : g_keep
         if (h < NARROW_W) begin : g_lo
            assign hi_keep[h] = 1'b1;
         end else begin : g_hi
            assign hi_keep[h] = ~narrow;
         end
      end
   endgenerate

   assign lvl[0] = src & hi_keep;

   genvar s;
   generate
      for (s = 0; s < SH_W; s++) begin : g_stage
         xperm_stage #(
            .DATA_W (DATA_W),
            .LEVEL  (s)
         ) u_stage (
            .swap (amt[s]),
            .din  (lvl[s]),
            .dout (lvl[s+1])
         );
      end
   endgenerate

   assign dst = lvl[SH_W];

endmodule

// File: rtl/xperm_cond.sv
module xperm_cond
   import xperm_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] value,
   input  logic              rec_en,
   output cond_t             cond
);

   logic is_zero;
   logic is_neg;

   assign is_zero = (value == '0);
   assign is_neg  = value[DATA_W-1];

   always_comb begin
      cond = '0;
      if (rec_en) begin
         cond[CND_NEG]  = is_neg;
         cond[CND_POS]  = ~is_neg & ~is_zero;
         cond[CND_ZERO] = is_zero;
         cond[CND_RSVD] = 1'b0;
      end
   end

endmodule

// File: rtl/xperm_unit.sv
module xperm_unit
   import xperm_pkg::*;
#(
   parameter int DATA_W   = 64,
   parameter int NARROW_W = 32,
   localparam int SH_W    = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] src_data,
   input  logic [SH_W-1:0]   amt_reg,
   input  logic [SH_W-1:0]   amt_imm,
   input  logic              use_imm,
   input  logic              narrow,
   input  logic              rec_en,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic [CND_W-1:0]  cond
);

   generate
      if (!is_pow2(DATA_W)) begin : g_bad_width
         $error("DATA_W must be a power of two");
      end
      if (!is_pow2(NARROW_W) || NARROW_W > DATA_W) begin : g_bad_narrow
         $error("NARROW_W must be a power of two not above DATA_W");
      end
   endgenerate

   logic [SH_W-1:0]   amt_eff;
   logic [DATA_W-1:0] perm_d;
   cond_t             cond_d;

   xperm_amt_sel #(
      .DATA_W   (DATA_W),
      .NARROW_W (NARROW_W)
   ) u_amt (
      .amt_reg (amt_reg),
      .amt_imm (amt_imm),
      .use_imm (use_imm),
      .narrow  (narrow),
      .amt_eff (amt_eff)
   );

   xperm_network #(
      .DATA_W   (DATA_W),
      .NARROW_W (NARROW_W)
   ) u_net (
      .src    (src_data),
      .amt    (amt_eff),
      .narrow (narrow),
      .dst    (perm_d)
   );

   xperm_cond #(
      .DATA_W (DATA_W)
   ) u_cond (
      .value  (perm_d),
      .rec_en (rec_en),
      .cond   (cond_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         cond      <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result <= perm_d;
            cond   <= cond_d;
         end
      end
   end

endmodule

// File: rtl/xperm_chk.sv
module xperm_chk
   import xperm_pkg::*;
#(
   parameter int DATA_W   = 64,
   parameter int NARROW_W = 32,
   localparam int SH_W    = $clog2(DATA_W)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [DATA_W-1:0] src_data,
   input logic [SH_W-1:0]   amt_imm,
   input logic              use_imm,
   input logic              narrow,
   input logic              rec_en,
   input logic              out_valid,
   input logic [DATA_W-1:0] result,
   input logic [CND_W-1:0]  cond
);

   function automatic logic [DATA_W-1:0] flip(input logic [DATA_W-1:0] v);
      logic [DATA_W-1:0] r;
      for (int i = 0; i < DATA_W; i++) r[DATA_W-1-i] = v[i];
      return r;
   endfunction

   // R2: one-cycle latency, streaming
   p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R4: narrow mode clears the upper half
   p_narrow_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && narrow) |=> (result[DATA_W-1:NARROW_W] == '0));

   // R6: zero amount passes through, all ones reverses (wide mode)
   p_zero_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && use_imm && amt_imm == '0 && !narrow) |=> (result == $past(src_data)));
   p_full_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && use_imm && amt_imm == '1 && !narrow) |=> (result == flip($past(src_data))));

   // R7: exactly one class bit, reserved bit clear, sign consistent
   p_cond_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && rec_en) |=> ($countones(cond[CND_NEG:CND_ZERO]) == 1 && !cond[CND_RSVD]));
   p_cond_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && cond[CND_NEG]) |-> result[DATA_W-1]);

   // R8: no record, no condition
   p_cond_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !rec_en) |=> (cond == '0));

   // R9: hold while idle
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(result) && $stable(cond)));

endmodule

bind xperm_unit xperm_chk #(
   .DATA_W   (DATA_W),
   .NARROW_W (NARROW_W)
) u_xperm_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .src_data  (src_data),
   .amt_imm   (amt_imm),
   .use_imm   (use_imm),
   .narrow    (narrow),
   .rec_en    (rec_en),
   .out_valid (out_valid),
   .result    (result),
   .cond      (cond)
);

// File: tb/xperm_unit_tb_top.sv
`timescale 1ns/1ps
module xperm_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] src_data = '0;
   logic [5:0]  amt_reg = '0;
   logic [5:0]  amt_imm = '0;
   logic        use_imm = 1'b0;
   logic        narrow = 1'b0;
   logic        rec_en = 1'b0;
   logic        out_valid;
   logic [63:0] result;
   logic [3:0]  cond;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   logic [67:0] exp_q [$];
   string       tag_q [$];

   always #4 clk = ~clk;   // 125 MHz

   xperm_unit dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .src_data  (src_data),
      .amt_reg   (amt_reg),
      .amt_imm   (amt_imm),
      .use_imm   (use_imm),
      .narrow    (narrow),
      .rec_en    (rec_en),
      .out_valid (out_valid),
      .result    (result),
      .cond      (cond)
   );

   // reference: direct index mapping, from the requirements
   function automatic logic [63:0] ref_perm(input logic [63:0] s, input logic [5:0] amt,
                                            input logic nw);
      logic [63:0] r = '0;
      int width = nw ? 32 : 64;
      int k = nw ? (int'(amt) % 32) : int'(amt);
      for (int i = 0; i < width; i++) r[i ^ k] = s[i];
      return r;
   endfunction

   function automatic logic [3:0] ref_cond(input logic [63:0] r, input logic rec);
      if (!rec) return 4'b0000;
      if (r[63]) return 4'b1000;
      if (r == 64'd0) return 4'b0010;
      return 4'b0100;
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // driver: push expectation, present operation for one cycle
   task automatic send(input string tag, input logic [63:0] s, input logic [5:0] ar,
                       input logic [5:0] ai, input logic ui, input logic nw, input logic rc);
      logic [63:0] e;
      e = ref_perm(s, ui ? ai : ar, nw);
      exp_q.push_back({ref_cond(e, rc), e});
      tag_q.push_back(tag);
      src_data = s; amt_reg = ar; amt_imm = ai; use_imm = ui; narrow = nw; rec_en = rc;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic send_lit(input string tag, input logic [63:0] s, input logic [5:0] ai,
                           input logic nw, input logic [63:0] lit);
      // literal cross-check of the model for structured patterns
      check({tag, " model"}, ref_perm(s, ai, nw), lit);
      send(tag, s, 6'd0, ai, 1'b1, nw, 1'b0);
   endtask

   // monitor
   logic [63:0] last_res;
   logic [3:0]  last_cond;
   bit          have_last = 0;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (out_valid) begin
            if (exp_q.size() == 0) begin
               check("R2 unexpected out_valid", 64'd1, 64'd0);
            end else begin
               logic [67:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check({t, " result"}, result, e[63:0]);
               check({t, " cond"}, {60'd0, cond}, {60'd0, e[67:64]});
            end
            last_res  = result;
            last_cond = cond;
            have_last = 1;
         end else if (have_last) begin
            check("R9 hold", {cond, result[59:0]}, {last_cond, last_res[59:0]});
         end
      end
   end

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [63:0] lf;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 out_valid", {63'd0, out_valid}, 64'd0);
      check("R1 result", result, 64'd0);
      check("R1 cond", {60'd0, cond}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle after reset", {59'd0, out_valid, cond}, 64'd0);

      // R6 structured amounts
      send_lit("R6 pass", 64'h0123456789ABCDEF, 6'd0, 1'b0, 64'h0123456789ABCDEF);
      send_lit("R6 byte order", 64'h0123456789ABCDEF, 6'd56, 1'b0, 64'hEFCDAB8967452301);
      send_lit("R6 reverse", 64'h0000000000000001, 6'd63, 1'b0, 64'h8000000000000000);
      // R3 nibble swap and single-bit move
      send_lit("R3 nibble", 64'h0123456789ABCDEF, 6'd4, 1'b0, 64'h1032547698BADCFE);
      send_lit("R3 bit move", 64'h0000000000000004, 6'd1, 1'b0, 64'h0000000000000008);
      @(negedge clk);
      // R4 narrow mode: upper cleared, amount modulo 32
      send_lit("R4 narrow pass", 64'hFFFF0000_12345678, 6'd0, 1'b1, 64'h00000000_12345678);
      send_lit("R4 narrow mod", 64'hDEADBEEF_00000001, 6'd33, 1'b1, 64'h00000000_00000002);
      send_lit("R4 narrow reverse", 64'hFFFFFFFF_00000001, 6'd63, 1'b1, 64'h00000000_80000000);
      // R5 source select: differing register and immediate amounts
      send("R5 imm", 64'h00000000000000F0, 6'd8, 6'd1, 1'b1, 1'b0, 1'b0);
      send("R5 reg", 64'h00000000000000F0, 6'd8, 6'd1, 1'b0, 1'b0, 1'b0);
      send("R5 reg narrow", 64'h000000000000F000, 6'd40, 6'd0, 1'b0, 1'b1, 1'b0);
      @(negedge clk);
      @(negedge clk);
      // R7 condition classes, R8 recording off
      send("R7 negative", 64'h0000000000000001, 6'd0, 6'd63, 1'b1, 1'b0, 1'b1);
      send("R7 positive", 64'h8000000000000000, 6'd0, 6'd63, 1'b1, 1'b0, 1'b1);
      send("R7 zero", 64'hFFFFFFFF00000000, 6'd0, 6'd0, 1'b1, 1'b1, 1'b1);
      send("R8 off negative", 64'h0000000000000001, 6'd0, 6'd63, 1'b1, 1'b0, 1'b0);
      send("R8 off zero", 64'd0, 6'd0, 6'd0, 1'b1, 1'b0, 1'b0);
      @(negedge clk);
      // R2 R3 back-to-back stream
      lf = 64'hACE1_1234_5678_9ABC;
      for (int n = 0; n < 200; n++) begin
         lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
         src_data = lf;
         send("R3 stream", lf, lf[5:0], lf[11:6], lf[12], lf[13], lf[14]);
         if (n % 37 == 36) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      check("R2 queue drained", 64'(exp_q.size()), 64'd0);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule